// File: doc/BRIEF.md
# Perspective Projection Transform Unit

This block handles one vertex per command inside a fixed-point geometry coprocessor. It rotates a signed 16-bit vertex by a 3x3 signed 16-bit matrix and adds a translation vector. It then clamps the results to 32-bit and 16-bit ranges, clamps the new depth to an unsigned 16-bit value, and divides the projection distance by that depth. From the quotient it forms a screen position and a depth-cue value. Every clamp sets its own sticky bit in a 32-bit status word, and a summary bit collects the serious ones.

Software loads the operands through a word-wide write port and then pulses `start_i`. `busy_o` stays high while the command runs. The quotient comes from a restoring divider that produces one bit per cycle. When the command ends, `done_o` pulses for one cycle. In that same cycle all results, the depth history (four entries) and the screen history (three entries) are updated.

Top module: `ppt_unit`

## Requirements
- R1: The operand registers are written at these addresses: 0..2 vertex X,Y,Z (low 16 bits); 3..11 matrix row-major (low 16 bits); 12..14 translation X,Y,Z; 15..16 screen offset X,Y; 17 projection distance H (low 16 bits, unsigned); 18 cue slope A (low 16 bits); 19 cue base B. A write is ignored while `busy_o` is high.
- R2: A `start_i` pulse while idle raises `busy_o` in the next cycle. `busy_o` stays high until the cycle in which `done_o` pulses for one cycle, and falls in that cycle. A `start_i` pulse while busy is ignored.
- R3: Each MACi (i=1..3) is computed at 64-bit width as (matrix row i · vertex + translation_i·4096), arithmetically shifted right by 12 and saturated to signed 32 bits. Positive overflow sets flag bit 31-i (30, 29, 28). Negative overflow sets bit 28-i (27, 26, 25).
- R4: IRi is MACi saturated to the signed 16-bit range. A clip sets flag bit 25-i (24, 23, 22).
- R5: The new depth is MAC3 clamped to 0..0xFFFF, and a clamp sets bit 18. The depth history shifts so that entry k takes entry k+1 and entry 3 takes the new depth.
- R6: The divisor is the new depth when floor(H/2) is less than the depth, and 1 otherwise. The divider is never given a zero divisor.
- R7: The quotient is (H·65536)/divisor. Above 0x1FFFF it is clamped to 0x1FFFF and sets bit 17.
- R8: Screen X/Y is computed as offset + IR1/IR2 · quotient, saturated to signed 32 bits, shifted arithmetically right by 16 and clamped to -0x400..0x3FF. Clamping X sets bit 14 and clamping Y sets bit 13. The 3-entry screen history shifts like the depth history, and each entry is {Y[15:0], X[15:0]}.
- R9: MAC0 is B + A·quotient, saturated to signed 32 bits. Positive overflow sets bit 16 and negative overflow sets bit 15.
- R10: IR0 is MAC0 shifted arithmetically right by 12 and clamped to 0..0x1000, and a clamp sets bit 12.
- R11: Bit 31 of the flag word is the OR of bits 30..23 and 18..13. Bits 22 and 12 do not feed it. The word is rebuilt from zero by every command and updated only at its end.
- R12: After reset, every output is zero and `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Operand write enable |
| wr_addr_i | input | 5 | Operand address |
| wr_data_i | input | 32 | Operand write data |
| start_i | input | 1 | Command start pulse |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mac_o | output | 128 | {MAC3, MAC2, MAC1, MAC0} |
| ir_o | output | 64 | {IR3, IR2, IR1, IR0} |
| sz_fifo_o | output | 64 | Depth history, entry 0 in bits 15:0 |
| sxy_fifo_o | output | 96 | Screen history, entry 0 in bits 31:0 |
| flag_o | output | 32 | Status flag word |

## Verification
The divider assertion relies on the divisor rule. That rule guarantees a non-zero divisor and a dividend whose upper 15 bits are already smaller than the divisor, so a 17-bit quotient cannot overflow. The register-stability assertion expects writes to come only through the port and gated by `busy_o`. The stimulus deliberately drives writes and start pulses during busy to show that they are dropped. The sweep crosses three matrices, six translations, six vertex values and five distances. These include the extreme 16- and 32-bit codes and the H/2 = depth boundary, so every clamp fires both ways and never fires.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
  localparam int VAL_W   = 16;
  localparam int WORD_W  = 32;
  localparam int ACC_W   = 64;
  localparam int ADDR_W  = 5;
  localparam int FRAC_SH = 12;
  localparam int SCR_SH  = 16;
  localparam int QUO_W   = 17;
  localparam int DVD_W   = 2 * VAL_W;

  localparam int A_VTX = 0;
  localparam int A_ROT = 3;
  localparam int A_TR  = 12;
  localparam int A_OFS = 15;
  localparam int A_H   = 17;
  localparam int A_DQA = 18;
  localparam int A_DQB = 19;

  localparam int F_SUM  = 31;
  localparam int F_MACP = 30;
  localparam int F_MACN = 27;
  localparam int F_IR   = 24;
  localparam int F_SZ   = 18;
  localparam int F_QUO  = 17;
  localparam int F_M0P  = 16;
  localparam int F_M0N  = 15;
  localparam int F_SCR  = 14;
  localparam int F_IR0  = 12;
  localparam logic [WORD_W-1:0] SUM_MASK = 32'h7F87_E000;

  typedef logic signed [ACC_W-1:0] acc_t;

  localparam acc_t S32_MAX = 64'sh0000_0000_7FFF_FFFF;
  localparam acc_t S32_MIN = -64'sh0000_0000_8000_0000;
  localparam acc_t S16_MAX = 64'sd32767;
  localparam acc_t S16_MIN = -64'sd32768;
  localparam acc_t U16_MAX = 64'sd65535;
  localparam acc_t SCR_MAX = 64'sd1023;
  localparam acc_t SCR_MIN = -64'sd1024;
  localparam acc_t IR0_MAX = 64'sd4096;

  typedef enum logic [1:0] {ST_IDLE, ST_ROT, ST_DIV, ST_PROJ} ppt_state_e;

  typedef struct packed {
    logic [2:0][VAL_W-1:0]  vtx;
    logic [8:0][VAL_W-1:0]  rot;
    logic [2:0][WORD_W-1:0] tr;
    logic [1:0][WORD_W-1:0] ofs;
    logic [VAL_W-1:0]       h;
    logic [VAL_W-1:0]       dqa;
    logic [WORD_W-1:0]      dqb;
  } ppt_regs_t;

  function automatic acc_t sext16(input logic [VAL_W-1:0] v);
    return {{(ACC_W-VAL_W){v[VAL_W-1]}}, v};
  endfunction

  function automatic acc_t sext32(input logic [WORD_W-1:0] v);
    return {{(ACC_W-WORD_W){v[WORD_W-1]}}, v};
  endfunction

  function automatic acc_t clamp(input acc_t x, input acc_t lo, input acc_t hi);
    return (x > hi) ? hi : ((x < lo) ? lo : x);
  endfunction

  function automatic logic [WORD_W-1:0] lo32(input acc_t x);
    return x[WORD_W-1:0];
  endfunction

  function automatic logic [VAL_W-1:0] lo16(input acc_t x);
    return x[VAL_W-1:0];
  endfunction
endpackage

// File: rtl/ppt_regfile.sv
module ppt_regfile import ppt_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] data_i,
  output ppt_regs_t         regs_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_o <= '0;
    end else if (we_i) begin
      for (int k = 0; k < 3; k++)
        if (addr_i == ADDR_W'(A_VTX + k)) regs_o.vtx[k] <= data_i[VAL_W-1:0];
      for (int k = 0; k < 9; k++)
        if (addr_i == ADDR_W'(A_ROT + k)) regs_o.rot[k] <= data_i[VAL_W-1:0];
      for (int k = 0; k < 3; k++)
        if (addr_i == ADDR_W'(A_TR + k)) regs_o.tr[k] <= data_i;
      for (int k = 0; k < 2; k++)
        if (addr_i == ADDR_W'(A_OFS + k)) regs_o.ofs[k] <= data_i;
      if (addr_i == ADDR_W'(A_H))   regs_o.h   <= data_i[VAL_W-1:0];
      if (addr_i == ADDR_W'(A_DQA)) regs_o.dqa <= data_i[VAL_W-1:0];
      if (addr_i == ADDR_W'(A_DQB)) regs_o.dqb <= data_i;
    end
  end
endmodule

// File: rtl/ppt_rotate.sv
module ppt_rotate import ppt_pkg::*; (
  input  logic [2:0][VAL_W-1:0]  vtx_i,
  input  logic [8:0][VAL_W-1:0]  rot_i,
  input  logic [2:0][WORD_W-1:0] tr_i,
  input  logic [VAL_W-1:0]       h_i,
  output logic [2:0][WORD_W-1:0] mac_o,
  output logic [2:0][VAL_W-1:0]  ir_o,
  output logic [VAL_W-1:0]       sz_o,
  output logic [WORD_W-1:0]      flag_o,
  output logic                   use_div_o,
  output logic [VAL_W-1:0]       divisor_o
);
  logic [2:0] ovp, ovn, irc;
  logic       sz_clip;

  for (genvar i = 0; i < 3; i++) begin : g_row
    acc_t sum_s, shf_s, mac_s;
    always_comb begin
      sum_s = sext16(rot_i[3*i])   * sext16(vtx_i[0])
            + sext16(rot_i[3*i+1]) * sext16(vtx_i[1])
            + sext16(rot_i[3*i+2]) * sext16(vtx_i[2])
            + (sext32(tr_i[i]) <<< FRAC_SH);
      shf_s = sum_s >>> FRAC_SH;
      mac_s = clamp(shf_s, S32_MIN, S32_MAX);
    end
    assign mac_o[i] = lo32(mac_s);
    assign ir_o[i]  = lo16(clamp(mac_s, S16_MIN, S16_MAX));
    assign ovp[i]   = shf_s > S32_MAX;
    assign ovn[i]   = shf_s < S32_MIN;
    assign irc[i]   = (mac_s > S16_MAX) || (mac_s < S16_MIN);
  end

  always_comb begin
    acc_t m3;
    m3      = sext32(mac_o[2]);
    sz_o    = lo16(clamp(m3, '0, U16_MAX));
    sz_clip = (m3 < 0) || (m3 > U16_MAX);
  end

  // near-plane rule: fall back to divisor 1
  assign use_div_o = (h_i >> 1) < sz_o;
  assign divisor_o = use_div_o ? sz_o : VAL_W'(1);

  always_comb begin
    flag_o = '0;
    for (int i = 0; i < 3; i++) begin
      flag_o[F_MACP-i] = ovp[i];
      flag_o[F_MACN-i] = ovn[i];
      flag_o[F_IR-i]   = irc[i];
    end
    flag_o[F_SZ] = sz_clip;
  end
endmodule

// File: rtl/ppt_divider.sv
module ppt_divider #(
  parameter int DVD_W = 32,
  parameter int DVS_W = 16,
  parameter int QUO_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             done_o,
  output logic [QUO_W-1:0] quotient_o
);
  localparam int CNT_W = $clog2(QUO_W + 1);

  logic [DVS_W-1:0] rem_q, dvs_q;
  logic [QUO_W-1:0] shr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [DVS_W:0]   trial;
  logic [DVS_W+1:0] diff;

  assign trial = {rem_q, shr_q[QUO_W-1]};
  assign diff  = {1'b0, trial} - {2'b00, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0; dvs_q <= '0; shr_q <= '0; cnt_q <= '0;
      run_q <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        // upper dividend bits are below the divisor, so QUO_W steps suffice
        rem_q <= DVS_W'(dividend_i[DVD_W-1:QUO_W]);
        shr_q <= dividend_i[QUO_W-1:0];
        dvs_q <= divisor_i;
        cnt_q <= CNT_W'(QUO_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= diff[DVS_W+1] ? trial[DVS_W-1:0] : diff[DVS_W-1:0];
        shr_q <= {shr_q[QUO_W-2:0], ~diff[DVS_W+1]};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quotient_o = shr_q;

  assert_div_safe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (divisor_i != '0) && ((dividend_i >> QUO_W) < DVD_W'(divisor_i)));
  assert_div_no_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> !start_i);
endmodule

// File: rtl/ppt_project.sv
module ppt_project import ppt_pkg::*; (
  input  logic [1:0][VAL_W-1:0]  ir_i,
  input  logic [QUO_W-1:0]       quo_i,
  input  logic [1:0][WORD_W-1:0] ofs_i,
  input  logic [VAL_W-1:0]       dqa_i,
  input  logic [WORD_W-1:0]      dqb_i,
  output logic [1:0][VAL_W-1:0]  scr_o,
  output logic [WORD_W-1:0]      mac0_o,
  output logic [VAL_W-1:0]       ir0_o,
  output logic [WORD_W-1:0]      flag_o
);
  acc_t quo_s;
  logic [1:0] scr_clip;

  assign quo_s = {{(ACC_W-QUO_W){1'b0}}, quo_i};

  for (genvar k = 0; k < 2; k++) begin : g_axis
    acc_t sum_s, shf_s;
    always_comb begin
      sum_s = sext32(ofs_i[k]) + sext16(ir_i[k]) * quo_s;
      shf_s = clamp(sum_s, S32_MIN, S32_MAX) >>> SCR_SH;
    end
    assign scr_o[k]    = lo16(clamp(shf_s, SCR_MIN, SCR_MAX));
    assign scr_clip[k] = (shf_s > SCR_MAX) || (shf_s < SCR_MIN);
  end

  acc_t m0_s, m0_sat, ir0_s;
  always_comb begin
    m0_s   = sext32(dqb_i) + sext16(dqa_i) * quo_s;
    m0_sat = clamp(m0_s, S32_MIN, S32_MAX);
    ir0_s  = m0_sat >>> FRAC_SH;
  end
  assign mac0_o = lo32(m0_sat);
  assign ir0_o  = lo16(clamp(ir0_s, '0, IR0_MAX));

  always_comb begin
    flag_o = '0;
    flag_o[F_M0P]   = m0_s > S32_MAX;
    flag_o[F_M0N]   = m0_s < S32_MIN;
    flag_o[F_SCR]   = scr_clip[0];
    flag_o[F_SCR-1] = scr_clip[1];
    flag_o[F_IR0]   = (ir0_s < 0) || (ir0_s > IR0_MAX);
  end
endmodule

// File: rtl/ppt_unit.sv
module ppt_unit import ppt_pkg::*; #(
  parameter int SZ_DEPTH  = 4,
  parameter int SXY_DEPTH = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [WORD_W-1:0]           wr_data_i,
  input  logic                        start_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic [4*WORD_W-1:0]         mac_o,
  output logic [4*VAL_W-1:0]          ir_o,
  output logic [SZ_DEPTH*VAL_W-1:0]   sz_fifo_o,
  output logic [SXY_DEPTH*WORD_W-1:0] sxy_fifo_o,
  output logic [WORD_W-1:0]           flag_o
);
  ppt_state_e state_q;
  ppt_regs_t  regs;

  logic [2:0][WORD_W-1:0] rot_mac, mac_q;
  logic [2:0][VAL_W-1:0]  rot_ir, ir_q;
  logic [VAL_W-1:0]       rot_sz, sz_q, rot_dvs, dvs_q;
  logic [WORD_W-1:0]      rot_flag, flag_q, prj_flag, flag_all;
  logic                   rot_use_div, use_div_q;
  logic [QUO_W-1:0]       quo_q, div_quo, quo_nodiv;
  logic                   div_done, div_start, nodiv_clip;
  logic [DVD_W-1:0]       h_scaled;
  logic [1:0][VAL_W-1:0]  prj_scr;
  logic [WORD_W-1:0]      prj_mac0;
  logic [VAL_W-1:0]       prj_ir0;

  assign busy_o = (state_q != ST_IDLE);

  ppt_regfile i_regfile (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en_i && !busy_o),
    .addr_i (wr_addr_i),
    .data_i (wr_data_i),
    .regs_o (regs)
  );

  ppt_rotate i_rotate (
    .vtx_i     (regs.vtx),
    .rot_i     (regs.rot),
    .tr_i      (regs.tr),
    .h_i       (regs.h),
    .mac_o     (rot_mac),
    .ir_o      (rot_ir),
    .sz_o      (rot_sz),
    .flag_o    (rot_flag),
    .use_div_o (rot_use_div),
    .divisor_o (rot_dvs)
  );

  assign h_scaled   = {regs.h, {VAL_W{1'b0}}};
  assign nodiv_clip = h_scaled > DVD_W'({QUO_W{1'b1}});
  assign quo_nodiv  = nodiv_clip ? {QUO_W{1'b1}} : h_scaled[QUO_W-1:0];
  assign div_start  = (state_q == ST_ROT) && use_div_q;

  ppt_divider #(.DVD_W(DVD_W), .DVS_W(VAL_W), .QUO_W(QUO_W)) i_divider (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .dividend_i (h_scaled),
    .divisor_i  (dvs_q),
    .done_o     (div_done),
    .quotient_o (div_quo)
  );

  ppt_project i_project (
    .ir_i   (ir_q[1:0]),
    .quo_i  (quo_q),
    .ofs_i  (regs.ofs),
    .dqa_i  (regs.dqa),
    .dqb_i  (regs.dqb),
    .scr_o  (prj_scr),
    .mac0_o (prj_mac0),
    .ir0_o  (prj_ir0),
    .flag_o (prj_flag)
  );

  assign flag_all = flag_q | prj_flag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mac_q <= '0; ir_q <= '0; sz_q <= '0; dvs_q <= '0; flag_q <= '0;
      use_div_q <= 1'b0; quo_q <= '0; done_o <= 1'b0;
      mac_o <= '0; ir_o <= '0; sz_fifo_o <= '0; sxy_fifo_o <= '0; flag_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mac_q     <= rot_mac;
          ir_q      <= rot_ir;
          sz_q      <= rot_sz;
          flag_q    <= rot_flag;
          use_div_q <= rot_use_div;
          dvs_q     <= rot_dvs;
          state_q   <= ST_ROT;
        end
        ST_ROT: begin
          if (use_div_q) begin
            state_q <= ST_DIV;
          end else begin
            quo_q         <= quo_nodiv;
            flag_q[F_QUO] <= nodiv_clip;
            state_q       <= ST_PROJ;
          end
        end
        ST_DIV: if (div_done) begin
          quo_q   <= div_quo;
          state_q <= ST_PROJ;
        end
        ST_PROJ: begin
          mac_o  <= {mac_q[2], mac_q[1], mac_q[0], prj_mac0};
          ir_o   <= {ir_q[2], ir_q[1], ir_q[0], prj_ir0};
          flag_o <= {|(flag_all & SUM_MASK), flag_all[F_SUM-1:0]};
          for (int k = 0; k < SZ_DEPTH-1; k++)
            sz_fifo_o[k*VAL_W +: VAL_W] <= sz_fifo_o[(k+1)*VAL_W +: VAL_W];
          sz_fifo_o[(SZ_DEPTH-1)*VAL_W +: VAL_W] <= sz_q;
          for (int k = 0; k < SXY_DEPTH-1; k++)
            sxy_fifo_o[k*WORD_W +: WORD_W] <= sxy_fifo_o[(k+1)*WORD_W +: WORD_W];
          sxy_fifo_o[(SXY_DEPTH-1)*WORD_W +: WORD_W] <= {prj_scr[1], prj_scr[0]};
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_regs_frozen_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(regs));
  assert_busy_from_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o ##1 !done_o);
  assert_sz_shift_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sz_fifo_o[(SZ_DEPTH-1)*VAL_W-1:0] == $past(sz_fifo_o[SZ_DEPTH*VAL_W-1:VAL_W]));
  assert_sxy_shift_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sxy_fifo_o[(SXY_DEPTH-1)*WORD_W-1:0] == $past(sxy_fifo_o[SXY_DEPTH*WORD_W-1:WORD_W]));
  assert_sx_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($signed(sxy_fifo_o[(SXY_DEPTH-1)*WORD_W +: VAL_W]) >= -16'sd1024) &&
               ($signed(sxy_fifo_o[(SXY_DEPTH-1)*WORD_W +: VAL_W]) <= 16'sd1023));
  assert_ir0_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ir_o[VAL_W-1:0] <= 16'h1000);
endmodule

// File: tb/test_ppt_unit.sv
module test_ppt_unit;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [4:0]   wr_addr_i = '0;
  logic [31:0]  wr_data_i = '0;
  logic         start_i = 1'b0;
  logic         busy_o, done_o;
  logic [127:0] mac_o;
  logic [63:0]  ir_o, sz_fifo_o;
  logic [95:0]  sxy_fifo_o;
  logic [31:0]  flag_o;

  int checks = 0;
  int errors = 0;

  always #5ns clk = ~clk;

  ppt_unit i_ppt_unit (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .mac_o(mac_o), .ir_o(ir_o), .sz_fifo_o(sz_fifo_o), .sxy_fifo_o(sxy_fifo_o),
    .flag_o(flag_o)
  );

  localparam longint S32MAX = 64'sd2147483647;
  localparam longint S32MIN = -64'sd2147483648;

  longint m_v[3], m_rot[9], m_tr[3], m_of[2], m_h, m_dqa, m_dqb;
  longint f_sz[4], f_sx[3], f_sy[3];
  logic [127:0] e_mac;
  logic [63:0]  e_ir, e_sz;
  logic [95:0]  e_sxy;
  logic [31:0]  e_flag;

  function automatic longint s16(longint x);
    logic [15:0] t = x[15:0];
    return $signed({{48{t[15]}}, t});
  endfunction
  function automatic longint s32(longint x);
    logic [31:0] t = x[31:0];
    return $signed({{32{t[31]}}, t});
  endfunction
  function automatic longint sat(longint x, longint lo, longint hi);
    return (x > hi) ? hi : ((x < lo) ? lo : x);
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_reg(int a, longint val);
    wr_en_i = 1'b1; wr_addr_i = 5'(a); wr_data_i = 32'(val);
    @(negedge clk);
    wr_en_i = 1'b0;
    if (a < 3) m_v[a] = s16(val);
    else if (a < 12) m_rot[a-3] = s16(val);
    else if (a < 15) m_tr[a-12] = s32(val);
    else if (a < 17) m_of[a-15] = s32(val);
    else if (a == 17) m_h = val & 64'hFFFF;
    else if (a == 18) m_dqa = s16(val);
    else if (a == 19) m_dqb = s32(val);
  endtask

  task automatic model_cmd();
    longint mac[3], ir[3], acc, sh, sz, dv, q, scr[2], t, m0, m0s, ir0;
    logic [31:0] f = '0;
    for (int i = 0; i < 3; i++) begin
      acc = m_rot[3*i]*m_v[0] + m_rot[3*i+1]*m_v[1] + m_rot[3*i+2]*m_v[2] + (m_tr[i] <<< 12);
      sh = acc >>> 12;
      if (sh > S32MAX) f[30-i] = 1'b1;
      if (sh < S32MIN) f[27-i] = 1'b1;
      mac[i] = sat(sh, S32MIN, S32MAX);
      ir[i] = sat(mac[i], -32768, 32767);
      if (ir[i] != mac[i]) f[24-i] = 1'b1;
    end
    sz = sat(mac[2], 0, 65535);
    if (sz != mac[2]) f[18] = 1'b1;
    dv = ((m_h >> 1) < sz) ? sz : 1;
    q = (m_h * 65536) / dv;
    if (q > 131071) begin q = 131071; f[17] = 1'b1; end
    for (int k = 0; k < 2; k++) begin
      t = sat(m_of[k] + ir[k]*q, S32MIN, S32MAX) >>> 16;
      scr[k] = sat(t, -1024, 1023);
      if (scr[k] != t) f[14-k] = 1'b1;
    end
    m0 = m_dqb + m_dqa*q;
    if (m0 > S32MAX) f[16] = 1'b1;
    if (m0 < S32MIN) f[15] = 1'b1;
    m0s = sat(m0, S32MIN, S32MAX);
    t = m0s >>> 12;
    ir0 = sat(t, 0, 4096);
    if (ir0 != t) f[12] = 1'b1;
    f[31] = (|f[30:23]) | (|f[18:13]);
    for (int k = 0; k < 3; k++) f_sz[k] = f_sz[k+1];
    f_sz[3] = sz;
    for (int k = 0; k < 2; k++) begin f_sx[k] = f_sx[k+1]; f_sy[k] = f_sy[k+1]; end
    f_sx[2] = scr[0]; f_sy[2] = scr[1];
    e_mac  = {32'(mac[2]), 32'(mac[1]), 32'(mac[0]), 32'(m0s)};
    e_ir   = {16'(ir[2]), 16'(ir[1]), 16'(ir[0]), 16'(ir0)};
    e_sz   = {16'(f_sz[3]), 16'(f_sz[2]), 16'(f_sz[1]), 16'(f_sz[0])};
    e_sxy  = {16'(f_sy[2]), 16'(f_sx[2]), 16'(f_sy[1]), 16'(f_sx[1]), 16'(f_sy[0]), 16'(f_sx[0])};
    e_flag = f;
  endtask

  task automatic run_cmd(bit noise);
    int n = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 busy after start", 128'(busy_o), 128'(1));
    if (noise) begin
      wr_en_i = 1'b1; wr_addr_i = 5'd2; wr_data_i = 32'h0000_1234; start_i = 1'b1;
      @(negedge clk);
      wr_en_i = 1'b0; start_i = 1'b0;
    end
    while (!done_o && n < 100) begin @(negedge clk); n++; end
    chk("R2 done with busy low", 128'({done_o, busy_o}), 128'(2'b10));
    model_cmd();
    chk("R3 R9 mac", mac_o, e_mac);
    chk("R4 R10 ir", 128'(ir_o), 128'(e_ir));
    chk("R5 depth fifo", 128'(sz_fifo_o), 128'(e_sz));
    chk("R6 R7 R8 screen fifo", 128'(sxy_fifo_o), 128'(e_sxy));
    chk("R11 flag word", 128'(flag_o), 128'(e_flag));
    chk("R7 quotient clamp bit", 128'(flag_o[17]), 128'(e_flag[17]));
    @(negedge clk);
  endtask

  task automatic load_all(int p, longint t, longint v, longint h, int idx);
    for (int k = 0; k < 9; k++) begin
      longint r;
      case (p)
        0: r = (k % 4 == 0) ? 64'sd4096 : 64'sd0;
        1: r = 64'sd32767;
        default: r = (k % 2 == 1) ? 64'sd2048 : -64'sd32768;
      endcase
      set_reg(3 + k, r);
    end
    set_reg(0, v); set_reg(1, -v); set_reg(2, v);
    set_reg(12, t); set_reg(13, -t); set_reg(14, t);
    case (idx % 3)
      0: set_reg(15, 64'sh7FFF_FFF0);
      1: set_reg(15, -64'sd327680);
      default: set_reg(15, 64'sh0123_0000);
    endcase
    set_reg(16, -m_of[0]);
    set_reg(17, h);
    set_reg(18, (idx % 2 == 1) ? 64'sd32767 : -64'sd4660);
    set_reg(19, (idx % 4) * 64'sh0300_0000 - 64'sh4000_0000);
  endtask

  longint tr_set[6] = '{0, 500, -700, 40000, 64'sh7FFF_FFFF, -64'sh8000_0000};
  longint v_set[6]  = '{0, 1, -1, 32767, -32768, 100};
  longint h_set[5]  = '{0, 1, 2, 1000, 65535};

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int idx = 0;
    for (int k = 0; k < 4; k++) f_sz[k] = 0;
    for (int k = 0; k < 3; k++) begin f_sx[k] = 0; f_sy[k] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 reset mac", mac_o, '0);
    chk("R12 reset ir/depth", 128'({ir_o, sz_fifo_o}), '0);
    chk("R12 reset screen/flag", 128'({sxy_fifo_o, flag_o}), '0);
    chk("R12 reset handshake", 128'({busy_o, done_o}), '0);

    // sweep: R3 R4 R5 R6 R7 R8 R9 R10 R11
    for (int p = 0; p < 3; p++)
      for (int ti = 0; ti < 6; ti++)
        for (int vi = 0; vi < 6; vi++)
          for (int hi = 0; hi < 5; hi++) begin
            load_all(p, tr_set[ti], v_set[vi], h_set[hi], idx);
            run_cmd(1'b0);
            idx++;
          end

    // R6 boundary: depth 500, H/2 equal to and just below depth
    load_all(0, 0, 500, 1000, 1);
    run_cmd(1'b0);
    set_reg(17, 999);
    run_cmd(1'b0);
    set_reg(17, 1001);
    run_cmd(1'b0);

    // R1 write and R2 start ignored during busy
    load_all(0, 200, 300, 400, 2);
    run_cmd(1'b1);
    repeat (4) @(negedge clk);
    chk("R2 extra start ignored", 128'({busy_o, done_o}), '0);
    run_cmd(1'b0);
    chk("R1 busy write dropped", 128'(mac_o[127:96]), 128'(e_mac[127:96]));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule